// File: doc/BRIEF.md
# Sequential Bank-Advance ROM Mapper

This block sits between an 8-bit console's cartridge bus and a 64 KB program image. The image is split into sixteen 4 KB banks, and only one bank is visible in the 4 KB cartridge window at a time. There is no bank-number register to write. Software moves to the following bank by touching one fixed hotspot offset in the window, and after the last bank it returns to the first. A debug host can raise a lock input so that its own accesses do not move the bank. The block also reports the current bank index and the total number of banks.

Each bus access is one cycle with the access strobe high. A read returns its byte one cycle later, flagged by a valid pulse. The image is generated from a fixed formula inside the block so that it needs no external loading. Bus decoding and console timing are handled outside the block.

Top module: `seq_bank_mapper`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `cur_bank` is 0, `rd_vld` is 0 and `rd_data` is 0.
- R2: `bank_count` always reads 16.
- R3: A read is a cycle with `acc_stb`=1 and `acc_wr`=0. In the cycle after a read, `rd_vld` is 1 and `rd_data` holds image byte idx = bank*4096 + offset, where the byte is idx[7:0] XOR idx[15:8] XOR 0x5A.
- R4: Only the low 12 bits of `acc_addr` are used. Addresses that differ only in bit 12 give the same data and the same hotspot decode.
- R5: An access at offset 0xFF0 while `bank_lock`=0 raises `cur_bank` by one. The new value is visible in the cycle after the access.
- R6: A read and a write at the hotspot each cause an advance. Each strobe cycle causes exactly one advance, and the hotspot address with `acc_stb`=0 has no effect.
- R7: An advance from bank 15 goes to bank 0.
- R8: While `bank_lock`=1, a hotspot access leaves `cur_bank` unchanged. A read under lock still returns data from the current bank.
- R9: A read at the hotspot returns the byte from the bank that was current before the advance.
- R10: An access at any offset other than 0xFF0 leaves `cur_bank` unchanged.
- R11: After a write, `rd_vld` is 0 in the next cycle and `rd_data` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_stb | input | 1 | Access strobe; one access per high cycle |
| acc_wr | input | 1 | 1 = write access, 0 = read access |
| acc_addr | input | 13 | Cartridge bus address; the low 12 bits are used |
| bank_lock | input | 1 | Freezes the bank while high |
| rd_data | output | 8 | Read data, registered |
| rd_vld | output | 1 | High for one cycle after each read |
| cur_bank | output | 4 | Current bank index |
| bank_count | output | 5 | Number of banks (16) |

## Verification
A read at the hotspot does two things in the same cycle: it fetches a byte and it advances the bank. Both take effect on one clock edge. The bench provokes this by reading 0xFF0, and also 0x1FF0, in several banks. The scoreboard expects the byte from the bank that was current before the advance, and a direct check expects `cur_bank` to be one higher on the following cycle. The same collision is repeated with the lock raised, where the fetch must still happen and the advance must not.

// File: rtl/seq_bank_mapper_pkg.sv
package seq_bank_mapper_pkg;

  localparam int unsigned DEF_BANKS    = 16;
  localparam int unsigned DEF_OFF_W    = 12;
  localparam int unsigned DEF_DATA_W   = 8;
  localparam int unsigned DEF_ADDR_W   = 13;
  localparam logic [11:0] DEF_HOT_OFF  = 12'hFF0;
  localparam logic [7:0]  DEF_IMG_SEED = 8'h5A;

  typedef enum logic [1:0] {
    ACC_IDLE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2
  } acc_kind_e;

endpackage

// File: rtl/sbm_addr_dec.sv
module sbm_addr_dec #(
  parameter int unsigned ADDR_W  = 13,
  parameter int unsigned OFF_W   = 12,
  parameter logic [OFF_W-1:0] HOT_OFF = '1
) (
  input  logic                               acc_stb,
  input  logic                               acc_wr,
  input  logic [ADDR_W-1:0]                  acc_addr,
  output logic [OFF_W-1:0]                   offset,
  output logic                               hot_hit,
  output seq_bank_mapper_pkg::acc_kind_e     kind
);
  import seq_bank_mapper_pkg::*;

  // Window offset: upper bus bits are ignored
  assign offset  = acc_addr[OFF_W-1:0];
  assign hot_hit = acc_stb && (offset == HOT_OFF);

  always_comb begin
    if (!acc_stb)    kind = ACC_IDLE;
    else if (acc_wr) kind = ACC_WRITE;
    else             kind = ACC_READ;
  end

endmodule

// File: rtl/sbm_bank_ctr.sv
module sbm_bank_ctr #(
  parameter int unsigned BANKS  = 16,
  parameter int unsigned BANK_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_req,
  input  logic              bank_lock,
  output logic [BANK_W-1:0] bank_q
);
  localparam logic [BANK_W-1:0] LAST_BANK = BANK_W'(BANKS - 1);

  logic [BANK_W-1:0] bank_inc;
  logic [BANK_W-1:0] bank_d;
  logic              bank_en;

  generate
    if (BANKS == (1 << BANK_W)) begin : g_pow2_wrap
      assign bank_inc = bank_q + BANK_W'(1);
    end else begin : g_cmp_wrap
      assign bank_inc = (bank_q == LAST_BANK) ? '0 : bank_q + BANK_W'(1);
    end
  endgenerate

  // Next-state: one step per strobed hotspot access, unless locked
  always_comb begin
    bank_en = step_req && !bank_lock;
    bank_d  = bank_inc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       bank_q <= '0;
    else if (bank_en) bank_q <= bank_d;
  end

endmodule

// File: rtl/sbm_image_rom.sv
module sbm_image_rom #(
  parameter int unsigned BANK_W = 4,
  parameter int unsigned OFF_W  = 12,
  parameter int unsigned DATA_W = 8,
  parameter logic [DATA_W-1:0] IMG_SEED = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_req,
  input  logic [BANK_W-1:0] bank,
  input  logic [OFF_W-1:0]  offset,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_vld
);
  localparam int unsigned IDX_W  = BANK_W + OFF_W;
  localparam int unsigned SLICES = (IDX_W + DATA_W - 1) / DATA_W;
  localparam int unsigned PAD_W  = SLICES * DATA_W;

  logic [IDX_W-1:0]  idx;
  logic [PAD_W-1:0]  idx_pad;
  logic [DATA_W-1:0] fold [SLICES+1];
  logic [DATA_W-1:0] byte_d;
  logic [DATA_W-1:0] data_d;

  assign idx     = {bank, offset};
  assign idx_pad = PAD_W'(idx);
  assign fold[0] = IMG_SEED;

  // Image content: XOR of all byte slices of the linear index with a seed
  generate
    for (genvar s = 0; s < SLICES; s++) begin : g_fold
      assign fold[s+1] = fold[s] ^ idx_pad[s*DATA_W +: DATA_W];
    end
  endgenerate

  assign byte_d = fold[SLICES];

  always_comb begin
    data_d = rd_req ? byte_d : rd_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data <= '0;
      rd_vld  <= 1'b0;
    end else begin
      rd_vld <= rd_req;
      if (rd_req) rd_data <= data_d;
    end
  end

endmodule

// File: rtl/seq_bank_mapper.sv
module seq_bank_mapper #(
  parameter int unsigned ADDR_W   = seq_bank_mapper_pkg::DEF_ADDR_W,
  parameter int unsigned OFF_W    = seq_bank_mapper_pkg::DEF_OFF_W,
  parameter int unsigned DATA_W   = seq_bank_mapper_pkg::DEF_DATA_W,
  parameter int unsigned BANKS    = seq_bank_mapper_pkg::DEF_BANKS,
  parameter logic [11:0] HOT_OFF  = seq_bank_mapper_pkg::DEF_HOT_OFF,
  parameter logic [7:0]  IMG_SEED = seq_bank_mapper_pkg::DEF_IMG_SEED,
  localparam int unsigned BANK_W  = $clog2(BANKS),
  localparam int unsigned CNT_W   = $clog2(BANKS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_stb,
  input  logic              acc_wr,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              bank_lock,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_vld,
  output logic [BANK_W-1:0] cur_bank,
  output logic [CNT_W-1:0]  bank_count
);
  import seq_bank_mapper_pkg::*;

  logic [OFF_W-1:0] offset;
  logic             hot_hit;
  acc_kind_e        kind;
  logic             rd_req;

  sbm_addr_dec #(
    .ADDR_W  (ADDR_W),
    .OFF_W   (OFF_W),
    .HOT_OFF (OFF_W'(HOT_OFF))
  ) u_dec (
    .acc_stb  (acc_stb),
    .acc_wr   (acc_wr),
    .acc_addr (acc_addr),
    .offset   (offset),
    .hot_hit  (hot_hit),
    .kind     (kind)
  );

  assign rd_req = (kind == ACC_READ);

  sbm_bank_ctr #(
    .BANKS  (BANKS),
    .BANK_W (BANK_W)
  ) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .step_req  (hot_hit),
    .bank_lock (bank_lock),
    .bank_q    (cur_bank)
  );

  // The fetch uses the registered bank, so a hotspot read sees the old bank
  sbm_image_rom #(
    .BANK_W   (BANK_W),
    .OFF_W    (OFF_W),
    .DATA_W   (DATA_W),
    .IMG_SEED (DATA_W'(IMG_SEED))
  ) u_rom (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_req  (rd_req),
    .bank    (cur_bank),
    .offset  (offset),
    .rd_data (rd_data),
    .rd_vld  (rd_vld)
  );

  assign bank_count = CNT_W'(BANKS);

endmodule

// File: rtl/seq_bank_mapper_chk.sv
module seq_bank_mapper_chk #(
  parameter int unsigned ADDR_W = 13,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned BANK_W = 4,
  parameter int unsigned BANKS  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              acc_stb,
  input logic              acc_wr,
  input logic [ADDR_W-1:0] acc_addr,
  input logic              bank_lock,
  input logic [DATA_W-1:0] rd_data,
  input logic              rd_vld,
  input logic [BANK_W-1:0] cur_bank
);
  logic hot_seen;
  assign hot_seen = acc_stb && (acc_addr[11:0] == 12'hFF0);

  // R8
  lock_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bank_lock |=> $stable(cur_bank));

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_stb |=> $stable(cur_bank));

  // R10
  off_hot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_stb && !hot_seen) |=> $stable(cur_bank));

  // R5
  step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hot_seen && !bank_lock && cur_bank != BANK_W'(BANKS - 1))
      |=> (cur_bank == $past(cur_bank) + BANK_W'(1)));

  // R7
  wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hot_seen && !bank_lock && cur_bank == BANK_W'(BANKS - 1))
      |=> (cur_bank == '0));

  // R3
  rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_stb && !acc_wr) |=> rd_vld);

  // R11
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_stb && acc_wr) |=> (!rd_vld && $stable(rd_data)));

endmodule

bind seq_bank_mapper seq_bank_mapper_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .BANK_W (BANK_W),
  .BANKS  (BANKS)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .acc_stb   (acc_stb),
  .acc_wr    (acc_wr),
  .acc_addr  (acc_addr),
  .bank_lock (bank_lock),
  .rd_data   (rd_data),
  .rd_vld    (rd_vld),
  .cur_bank  (cur_bank)
);

// File: tb/seq_bank_mapper_bench.sv
module seq_bank_mapper_bench;

  logic        clk;
  logic        rst_n;
  logic        acc_stb;
  logic        acc_wr;
  logic [12:0] acc_addr;
  logic        bank_lock;
  logic [7:0]  rd_data;
  logic        rd_vld;
  logic [3:0]  cur_bank;
  logic [4:0]  bank_count;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [7:0] exp_q [$];
  string      tag_q [$];
  logic [3:0] model_bank;
  logic [7:0] last_byte;

  seq_bank_mapper u_seq_bank_mapper (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc_stb    (acc_stb),
    .acc_wr     (acc_wr),
    .acc_addr   (acc_addr),
    .bank_lock  (bank_lock),
    .rd_data    (rd_data),
    .rd_vld     (rd_vld),
    .cur_bank   (cur_bank),
    .bank_count (bank_count)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [7:0] img(input logic [3:0] b, input logic [11:0] off);
    logic [15:0] idx;
    idx = {b, off};
    return idx[7:0] ^ idx[15:8] ^ 8'h5A;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Driver: one strobe cycle, expected read data goes to the scoreboard
  task automatic access(input bit wr, input logic [12:0] addr, input string tag);
    @(negedge clk);
    acc_stb  = 1'b1;
    acc_wr   = wr;
    acc_addr = addr;
    if (!wr) begin
      last_byte = img(model_bank, addr[11:0]);
      exp_q.push_back(last_byte);
      tag_q.push_back(tag);
    end
    if (addr[11:0] == 12'hFF0 && !bank_lock) model_bank = model_bank + 4'd1;
    @(negedge clk);
    acc_stb = 1'b0;
    acc_wr  = 1'b0;
  endtask

  // Monitor: pop and compare each returned read
  always @(negedge clk) begin
    if (rst_n && rd_vld) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R3 unexpected rd_vld", int'(rd_data), 0);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(rd_data == e, t, int'(rd_data), int'(e));
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      check(1'b0, "watchdog", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; acc_stb = 1'b0; acc_wr = 1'b0; acc_addr = '0; bank_lock = 1'b0;
    model_bank = '0; last_byte = '0;
    repeat (3) @(negedge clk);
    check(cur_bank == 4'd0 && rd_vld == 1'b0 && rd_data == 8'd0, "R1 in reset",
          int'({rd_vld, rd_data, cur_bank}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(cur_bank == 4'd0 && rd_vld == 1'b0 && rd_data == 8'd0, "R1 after release",
          int'({rd_vld, rd_data, cur_bank}), 0);
    check(bank_count == 5'd16, "R2 bank count", int'(bank_count), 16);

    // Plain reads in bank 0
    access(1'b0, 13'h0000, "R3 read 0x000");
    access(1'b0, 13'h0123, "R3 read 0x123");
    access(1'b0, 13'h0FEF, "R3 read 0xFEF");
    access(1'b0, 13'h1123, "R4 bit12 masked read");
    check(cur_bank == 4'd0, "R10 reads off hotspot", int'(cur_bank), 0);

    // Hotspot read: old-bank data, then advance
    access(1'b0, 13'h1FF0, "R9 hotspot read old bank");
    check(cur_bank == 4'd1, "R5 advance after hotspot read", int'(cur_bank), 1);
    access(1'b0, 13'h0456, "R3 read in bank 1");

    // Hotspot write advances, read output held
    access(1'b1, 13'h0FF0, "R6 write");
    check(cur_bank == 4'd2, "R6 write at hotspot advances", int'(cur_bank), 2);
    check(rd_vld == 1'b0 && rd_data == last_byte, "R11 write leaves read port",
          int'({rd_vld, rd_data}), int'({1'b0, last_byte}));

    // Neighbouring offsets do not advance
    access(1'b1, 13'h0FF1, "R10 write 0xFF1");
    access(1'b0, 13'h0FEF, "R10 read 0xFEF bank 2");
    check(cur_bank == 4'd2, "R10 non-hotspot", int'(cur_bank), 2);

    // Hotspot address without strobe
    @(negedge clk);
    acc_addr = 13'h0FF0;
    repeat (4) @(negedge clk);
    check(cur_bank == 4'd2, "R6 no strobe no advance", int'(cur_bank), 2);

    // Lock
    bank_lock = 1'b1;
    access(1'b0, 13'h0FF0, "R8 locked hotspot read");
    access(1'b1, 13'h1FF0, "R8 locked write");
    check(cur_bank == 4'd2, "R8 lock holds bank", int'(cur_bank), 2);
    bank_lock = 1'b0;

    // Walk to bank 15 with reads of the hotspot, then wrap
    for (int i = 2; i < 15; i++) begin
      access(1'b0, 13'h0FF0, "R9 hotspot read walk");
      check(cur_bank == 4'(i + 1), "R5 walk step", int'(cur_bank), i + 1);
    end
    access(1'b0, 13'h0ABC, "R3 read bank 15");
    access(1'b0, 13'h1FF0, "R9 hotspot read bank 15");
    check(cur_bank == 4'd0, "R7 wrap to 0", int'(cur_bank), 0);
    access(1'b0, 13'h0ABC, "R7 read after wrap");
    check(bank_count == 5'd16, "R2 bank count late", int'(bank_count), 16);

    repeat (2) @(negedge clk);
    check(exp_q.size() == 0, "R3 all reads returned", exp_q.size(), 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule